// File: doc/BRIEF.md
# Cycle-Shared Single-Port FIFO

This block is a synchronous first-in first-out buffer that holds its words in a single-port RAM instead of a dual-port memory. The RAM runs from a second clock at twice the system rate, with its rising edges phase-aligned to the system clock. A select flip-flop toggles on every double-rate edge. It steers the RAM address to the read pointer in the first half of each system cycle and to the write pointer in the second half. As a result, one read and one write can both complete within a single system cycle.

A consumer raises the read request and a producer raises the write request during a system cycle. A read is refused while the buffer is empty, and a write is refused while it is full. An up/down occupancy counter drives the empty, full and threshold flags. The threshold flag compares the occupancy against a level supplied on an input. A granted word appears on the read data output right after the system edge that closes the request cycle. The output keeps that word until the next granted read.

Top module: `cs_fifo`

## Requirements
- R1: A synchronous reset clears both pointers, the occupancy and the slot select. After reset, empty is 1, full is 0, the threshold flag is 0 and the read data is 0.
- R2: Words come out in the order they were accepted. The word of a read granted in system cycle n is on the read data output from the system edge that ends cycle n onwards.
- R3: A read request while empty is not granted. The read data keeps its value and empty stays 1.
- R4: A write request while full is not granted. The refused word never appears at the output, and the stored words come out unchanged.
- R5: When a read and a write are both granted in one cycle, the read returns the oldest word and the occupancy is unchanged.
- R6: Empty is 1 exactly when the occupancy is 0. Full is 1 exactly when the occupancy equals the depth.
- R7: The threshold flag is 1 exactly when the occupancy is strictly greater than the threshold level input. It follows that input without waiting for a clock.
- R8: Pointers wrap modulo the depth, which is a power of two, so streaming past the depth keeps the order.
- R9: The read data holds its last value in every cycle with no granted read.
- R10: With the buffer full and both requests raised, only the read is granted and the occupancy drops by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| clk_2x | input | 1 | Double-rate RAM clock, rising edges aligned to clk_sys |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| thresh_lvl | input | $clog2(DEPTH+1) | Threshold level |
| rd_data | output | WIDTH | Word from the last granted read |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| above_thresh | output | 1 | Occupancy greater than thresh_lvl |

## Verification
The assertions assume that every input, reset included, changes only in the first half of a system cycle. This keeps the value seen at the mid-cycle double-rate edge equal to the value seen at the closing system edge, and it keeps the slot select in step after reset. They also assume the double-rate clock has exactly two rising edges per system period, one of them coincident with the system edge. The bench generates both clocks from one process and drives every input one nanosecond after a system edge, so both assumptions hold throughout.

// File: rtl/cs_fifo.sv
module cs_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk_sys,
  input  logic                         clk_2x,
  input  logic                         rst,
  input  logic                         rd_req,
  input  logic                         wr_req,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic [$clog2(DEPTH+1)-1:0]   thresh_lvl,
  output logic [WIDTH-1:0]             rd_data,
  output logic                         empty,
  output logic                         full,
  output logic                         above_thresh
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    occ;
  logic             rd_ok, wr_ok;
  logic             wr_slot;
  logic [AW-1:0]    ram_addr;
  logic [WIDTH-1:0] ram_q, wdata_q;
  logic [WIDTH-1:0] mem [DEPTH];

  assign empty        = (occ == '0);
  assign full         = (occ == FULL_CNT);
  assign above_thresh = (occ > thresh_lvl);
  assign rd_ok        = rd_req && !empty;
  assign wr_ok        = wr_req && !full;

  // system-rate pointers and occupancy
  always_ff @(posedge clk_sys) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // slot select: 0 = read slot (first half), 1 = write slot (second half)
  always_ff @(posedge clk_2x) begin
    if (rst) wr_slot <= 1'b0;
    else     wr_slot <= ~wr_slot;
  end

  assign ram_addr = wr_slot ? wr_ptr : rd_ptr;

  always_ff @(posedge clk_2x) begin
    if (wr_slot && wr_ok) mem[ram_addr] <= wdata_q;
    ram_q <= mem[ram_addr];
  end

  always_ff @(posedge clk_2x) begin
    if (!wr_slot) wdata_q <= wr_data;
  end

  always_ff @(posedge clk_2x) begin
    if (rst)                  rd_data <= '0;
    else if (wr_slot && rd_ok) rd_data <= ram_q;
  end
endmodule

module cs_fifo_chk #(
  parameter int CW = 5
) (
  input logic          clk_sys,
  input logic          rst,
  input logic          rd_req,
  input logic          wr_req,
  input logic          empty,
  input logic          full,
  input logic [CW-1:0] occ
);
  localparam logic [CW-1:0] ONE = CW'(1);

  a_r3_no_read_when_empty: assert property (@(posedge clk_sys) disable iff (rst)
    (empty && !wr_req) |=> empty);

  a_r4_no_write_when_full: assert property (@(posedge clk_sys) disable iff (rst)
    (full && !rd_req) |=> full);

  a_r5_both_hold_count: assert property (@(posedge clk_sys) disable iff (rst)
    (rd_req && wr_req && !empty && !full) |=> $stable(occ));

  a_r6_write_leaves_empty: assert property (@(posedge clk_sys) disable iff (rst)
    (empty && wr_req) |=> !empty);

  a_r10_read_leaves_full: assert property (@(posedge clk_sys) disable iff (rst)
    (full && rd_req) |=> !full);

  a_r6_count_steps_by_one: assert property (@(posedge clk_sys) disable iff (rst)
    !$isunknown(occ) |=> ((occ == $past(occ)) || (occ == $past(occ) + ONE) || (occ + ONE == $past(occ))));
endmodule

bind cs_fifo cs_fifo_chk #(.CW(CW)) u_chk (
  .clk_sys(clk_sys),
  .rst    (rst),
  .rd_req (rd_req),
  .wr_req (wr_req),
  .empty  (empty),
  .full   (full),
  .occ    (occ)
);

// File: tb/cs_fifo_tb_top.sv
module cs_fifo_tb_top;
  localparam int W  = 8;
  localparam int D  = 4;
  localparam int CW = $clog2(D+1);

  logic clk_sys, clk_2x, rst, rd_req, wr_req, empty, full, above;
  logic [W-1:0]  wr_data, rd_data;
  logic [CW-1:0] thresh;
  int checks = 0, failures = 0;
  bit done = 0;

  cs_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk_sys(clk_sys), .clk_2x(clk_2x), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
    .wr_data(wr_data), .thresh_lvl(thresh), .rd_data(rd_data), .empty(empty),
    .full(full), .above_thresh(above));

  // 125 MHz system clock, 250 MHz double-rate clock, rising edges aligned
  initial begin
    clk_2x = 0; clk_sys = 0;
    forever begin
      #2 clk_2x = ~clk_2x;
      if (clk_2x) clk_sys = ~clk_sys;
    end
  end

  // {rd, wr, wdata, exp_rdata, exp_empty, exp_full, exp_above}, threshold = 2, depth 4
  localparam logic [20:0] VEC [16] = '{
    {1'b0, 1'b1, 8'hA1, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'hA2, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hA3, 8'hA1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'hA4, 8'hA1, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'hA5, 8'hA1, 1'b0, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'hA6, 8'hA1, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'hA7, 8'hA2, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h00, 8'hA2, 1'b0, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h00, 8'hA3, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 8'hA4, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 8'hA5, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 8'hA5, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'hA8, 8'hA5, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hA9, 8'hA8, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hAA, 8'hA9, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 8'hAA, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [W-1:0] d);
    rd_req = r; wr_req = w; wr_data = d;
    @(posedge clk_sys); #1;
  endtask

  initial begin
    rst = 1; rd_req = 0; wr_req = 0; wr_data = '0; thresh = CW'(2);
    repeat (4) @(posedge clk_sys);
    #1;
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 above", 32'(above), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
    rst = 0;

    // R2 R3 R4 R5 R6 R7 R8 R9 R10 over the vector walk
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][20], VEC[i][19], VEC[i][18:11]);
      chk($sformatf("R2/R9 rd_data v%0d", i), 32'(rd_data), 32'(VEC[i][10:3]));
      chk($sformatf("R6 empty v%0d", i), 32'(empty), 32'(VEC[i][2]));
      chk($sformatf("R6/R10 full v%0d", i), 32'(full), 32'(VEC[i][1]));
      chk($sformatf("R7 above v%0d", i), 32'(above), 32'(VEC[i][0]));
    end

    // R7: strict comparison, combinational in the level input
    step(0, 1, 8'hB1); step(0, 1, 8'hB2); step(0, 1, 8'hB3);
    rd_req = 0; wr_req = 0;
    thresh = CW'(3); #1; chk("R7 equal level", 32'(above), 0);
    thresh = CW'(2); #1; chk("R7 below level", 32'(above), 1);
    thresh = CW'(4); #1; chk("R7 above level", 32'(above), 0);
    step(0, 0, 8'h00);
    chk("R9 idle hold", 32'(rd_data), 32'hAA);

    // R1: reset while holding data
    rst = 1;
    step(0, 0, 8'h00); step(0, 0, 8'h00);
    chk("R1 reset empty", 32'(empty), 1);
    chk("R1 reset rd_data", 32'(rd_data), 0);
    rst = 0;
    step(1, 0, 8'h00);
    chk("R3 read after reset", 32'(rd_data), 0);
    chk("R3 still empty", 32'(empty), 1);
    step(0, 1, 8'hC7);
    step(1, 0, 8'h00);
    chk("R2 first word after reset", 32'(rd_data), 32'hC7);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule